// File: doc/BRIEF.md
# Byte RAM Pattern and Retention Tester

This engine drives a byte-wide single-port RAM interface and tests a window of it, given by a base address and a byte count. A run has three phases in a fixed order. The first is a quick per-location check with the two checkerboard bytes. The second is a moving-inversions march over the whole window in both directions. The third is a retention check: the whole window is filled, left alone for a programmable number of cycles, and then read back, once with each checkerboard byte.

The engine stops at the first read that does not match. It then reports the phase, the address, the expected and returned bytes, and the index of the RAM device that holds the address. The device index comes from a small table of ascending device base addresses. The RAM returns read data one cycle after a read strobe. The wait count and the device table must stay stable while a run is in progress.

Top module: `ram_march_tester`

## Requirements
- R1: After reset, busy, done, fail, mem_we and mem_re are all low.
- R2: Phase code 1 (quick) visits addresses in ascending order. At each address it writes 0x55, reads and compares, then writes 0xAA, reads and compares, before it moves to the next address.
- R3: Phase code 2 (march) writes 0x00 to every address in ascending order. It then makes these passes in turn, with each read compared before the write at the same address: ascending read 0x00/write 0xFF, ascending read 0xFF/write 0x00, descending read 0x00/write 0xFF, descending read 0xFF/write 0x00, and a final ascending read-only pass expecting 0x00.
- R4: Phase code 3 (retention) writes 0x55 to all addresses in ascending order, stays idle, and then reads all addresses in ascending order. It repeats this with 0xAA. The last fill write and the first readback are exactly cfg_wait+2 cycles apart.
- R5: Read data is compared in the cycle after mem_re. The interface makes no access in that cycle.
- R6: On the first miscompare the engine raises fail and done and makes no further RAM access. fail_phase, fail_addr, fail_expect and fail_actual report the phase code, the address, the expected byte and the returned byte.
- R7: fail_dev is the largest index i whose base (cfg_dev_base bits i*ADDR_W upward) is at or below the failing address, or 0 if no base is. The bases are ascending.
- R8: Every access falls inside [cfg_base, cfg_base+cfg_size). Memory outside the window is never written.
- R9: A start with cfg_size equal to 0 raises done in the next cycle, with no access and with fail low.
- R10: The results hold until the next start. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (ignored while busy) |
| cfg_base | input | ADDR_W | First address of the window |
| cfg_size | input | ADDR_W+1 | Number of bytes in the window |
| cfg_wait | input | WAIT_W | Retention idle count |
| cfg_dev_base | input | N_DEV*ADDR_W | Ascending device base addresses |
| mem_addr | output | ADDR_W | RAM address |
| mem_we | output | 1 | RAM write strobe |
| mem_re | output | 1 | RAM read strobe |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, valid one cycle after mem_re |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished (pass or fail) |
| fail | output | 1 | Run stopped on a miscompare |
| fail_phase | output | 2 | Phase code of the failure |
| fail_addr | output | ADDR_W | Failing address |
| fail_dev | output | DEV_W | Device index of the failing address |
| fail_expect | output | 8 | Expected byte |
| fail_actual | output | 8 | Returned byte |

## Verification
A wrong pass index, address counter or sub-step bit shows up at once in the RAM access stream. The bench therefore compares every strobe, address and write byte of fault-free runs against a sequence it builds itself, so a fault is caught on the first cycle it goes astray. Faults injected into the RAM model (stuck bits swept over every address, aliased cells in both orders, a cell that leaks while idle) must each stop the run at an address, phase and device that the bench can compute. A wrong hold counter shows up as a wrong gap before the first readback.

// File: rtl/rmt_pkg.sv
package rmt_pkg;

    localparam int DW = 8;
    localparam logic [DW-1:0] PAT_A = 8'h55;
    localparam logic [DW-1:0] PAT_B = 8'hAA;
    localparam int NUM_PASSES = 13;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR,
        ST_RD,
        ST_CHK,
        ST_HOLD,
        ST_DONE,
        ST_FAIL
    } st_e;

    // one pass of the run: what is done at each address
    typedef struct packed {
        logic [1:0]    phase;
        logic          desc;
        logic          quick;
        logic          rd;
        logic          wr;
        logic          hold;
        logic [DW-1:0] rexp;
        logic [DW-1:0] wdat;
    } pass_t;

    function automatic pass_t pass_info(input logic [3:0] idx);
        pass_t p;
        p = '0;
        case (idx)
            4'd0:  begin p.phase = 2'd1; p.quick = 1'b1; end
            4'd1:  begin p.phase = 2'd2; p.wr = 1'b1; p.wdat = 8'h00; end
            4'd2:  begin p.phase = 2'd2; p.rd = 1'b1; p.rexp = 8'h00; p.wr = 1'b1; p.wdat = 8'hFF; end
            4'd3:  begin p.phase = 2'd2; p.rd = 1'b1; p.rexp = 8'hFF; p.wr = 1'b1; p.wdat = 8'h00; end
            4'd4:  begin p.phase = 2'd2; p.desc = 1'b1; p.rd = 1'b1; p.rexp = 8'h00; p.wr = 1'b1; p.wdat = 8'hFF; end
            4'd5:  begin p.phase = 2'd2; p.desc = 1'b1; p.rd = 1'b1; p.rexp = 8'hFF; p.wr = 1'b1; p.wdat = 8'h00; end
            4'd6:  begin p.phase = 2'd2; p.rd = 1'b1; p.rexp = 8'h00; end
            4'd7:  begin p.phase = 2'd3; p.wr = 1'b1; p.wdat = PAT_A; end
            4'd8:  begin p.phase = 2'd3; p.hold = 1'b1; end
            4'd9:  begin p.phase = 2'd3; p.rd = 1'b1; p.rexp = PAT_A; end
            4'd10: begin p.phase = 2'd3; p.wr = 1'b1; p.wdat = PAT_B; end
            4'd11: begin p.phase = 2'd3; p.hold = 1'b1; end
            4'd12: begin p.phase = 2'd3; p.rd = 1'b1; p.rexp = PAT_B; end
            default: p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/rmt_hold_timer.sv
module rmt_hold_timer #(
    parameter int WAIT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              enable,
    input  logic [WAIT_W-1:0] limit,
    output logic              expired
);

    logic [WAIT_W-1:0] cnt_d, cnt_q;

    assign expired = (cnt_q == limit);

    always_comb begin
        cnt_d = cnt_q;
        if (clear)
            cnt_d = '0;
        else if (enable && !expired)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4
    hold_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enable |-> (cnt_q <= limit));

endmodule

// File: rtl/rmt_dev_decode.sv
module rmt_dev_decode #(
    parameter int ADDR_W = 8,
    parameter int N_DEV  = 4,
    parameter int DEV_W  = 2
) (
    input  logic [ADDR_W-1:0]       addr,
    input  logic [N_DEV*ADDR_W-1:0] bases,
    output logic [DEV_W-1:0]        idx
);

    logic [N_DEV-1:0] hit;

    for (genvar i = 0; i < N_DEV; i++) begin : g_cmp
        assign hit[i] = (addr >= bases[i*ADDR_W +: ADDR_W]);
    end

    // ascending bases: the highest matching entry wins
    always_comb begin
        idx = '0;
        for (int i = 0; i < N_DEV; i++)
            if (hit[i]) idx = DEV_W'(i);
    end

endmodule

// File: rtl/ram_march_tester.sv
module ram_march_tester
    import rmt_pkg::*;
#(
    parameter  int ADDR_W = 8,
    parameter  int N_DEV  = 4,
    parameter  int WAIT_W = 32,
    localparam int DEV_W  = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [ADDR_W-1:0]       cfg_base,
    input  logic [ADDR_W:0]         cfg_size,
    input  logic [WAIT_W-1:0]       cfg_wait,
    input  logic [N_DEV*ADDR_W-1:0] cfg_dev_base,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic                    mem_we,
    output logic                    mem_re,
    output logic [7:0]              mem_wdata,
    input  logic [7:0]              mem_rdata,
    output logic                    busy,
    output logic                    done,
    output logic                    fail,
    output logic [1:0]              fail_phase,
    output logic [ADDR_W-1:0]       fail_addr,
    output logic [DEV_W-1:0]        fail_dev,
    output logic [7:0]              fail_expect,
    output logic [7:0]              fail_actual
);

    localparam logic [3:0]    LAST_PASS = 4'(NUM_PASSES - 1);
    localparam logic [ADDR_W:0] ONE     = 1;

    typedef struct packed {
        st_e               st;
        logic [3:0]        pass;
        logic              sub;
        logic [ADDR_W:0]   cnt;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W:0]   size;
        logic [1:0]        f_phase;
        logic [ADDR_W-1:0] f_addr;
        logic [DEV_W-1:0]  f_dev;
        logic [DW-1:0]     f_exp;
        logic [DW-1:0]     f_got;
    } regs_t;

    regs_t r_d, r_q;

    pass_t             pi, pn;
    logic [ADDR_W:0]   off;
    logic [ADDR_W-1:0] cur_addr;
    logic [DW-1:0]     pat, exp_val, wr_val;
    logic              last_addr, last_pass, adv;
    logic              hold_expired;
    logic [DEV_W-1:0]  dev_idx;

    function automatic st_e entry_state(input pass_t p);
        if (p.hold)                 return ST_HOLD;
        else if (p.quick || !p.rd)  return ST_WR;
        else                        return ST_RD;
    endfunction

    rmt_hold_timer #(.WAIT_W(WAIT_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (r_q.st != ST_HOLD),
        .enable  (r_q.st == ST_HOLD),
        .limit   (cfg_wait),
        .expired (hold_expired)
    );

    rmt_dev_decode #(.ADDR_W(ADDR_W), .N_DEV(N_DEV), .DEV_W(DEV_W)) u_dec (
        .addr  (cur_addr),
        .bases (cfg_dev_base),
        .idx   (dev_idx)
    );

    always_comb begin
        pi        = pass_info(r_q.pass);
        pn        = pass_info(r_q.pass + 4'd1);
        off       = pi.desc ? (r_q.size - r_q.cnt - ONE) : r_q.cnt;
        cur_addr  = r_q.base + off[ADDR_W-1:0];
        pat       = r_q.sub ? PAT_B : PAT_A;
        exp_val   = pi.quick ? pat : pi.rexp;
        wr_val    = pi.quick ? pat : pi.wdat;
        last_addr = (r_q.cnt == r_q.size - ONE);
        last_pass = (r_q.pass == LAST_PASS);
        adv       = 1'b0;
        r_d       = r_q;

        case (r_q.st)
            ST_IDLE, ST_DONE, ST_FAIL: begin
                if (start) begin
                    r_d.base = cfg_base;
                    r_d.size = cfg_size;
                    r_d.cnt  = '0;
                    r_d.pass = '0;
                    r_d.sub  = 1'b0;
                    r_d.st   = (cfg_size == '0) ? ST_DONE : entry_state(pass_info(4'd0));
                end
            end
            ST_WR: begin
                if (pi.quick) r_d.st = ST_RD;
                else          adv = 1'b1;
            end
            ST_RD: r_d.st = ST_CHK;
            ST_CHK: begin
                if (mem_rdata != exp_val) begin
                    r_d.st      = ST_FAIL;
                    r_d.f_phase = pi.phase;
                    r_d.f_addr  = cur_addr;
                    r_d.f_dev   = dev_idx;
                    r_d.f_exp   = exp_val;
                    r_d.f_got   = mem_rdata;
                end else if (pi.quick && !r_q.sub) begin
                    r_d.sub = 1'b1;
                    r_d.st  = ST_WR;
                end else if (pi.quick) begin
                    adv = 1'b1;
                end else if (pi.wr) begin
                    r_d.st = ST_WR;
                end else begin
                    adv = 1'b1;
                end
            end
            ST_HOLD: begin
                if (hold_expired) begin
                    r_d.pass = r_q.pass + 4'd1;
                    r_d.cnt  = '0;
                    r_d.st   = entry_state(pn);
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (adv) begin
            r_d.sub = 1'b0;
            if (!last_addr) begin
                r_d.cnt = r_q.cnt + ONE;
                r_d.st  = entry_state(pi);
            end else if (last_pass) begin
                r_d.st = ST_DONE;
            end else begin
                r_d.pass = r_q.pass + 4'd1;
                r_d.cnt  = '0;
                r_d.st   = entry_state(pn);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mem_addr    = cur_addr;
    assign mem_we      = (r_q.st == ST_WR);
    assign mem_re      = (r_q.st == ST_RD);
    assign mem_wdata   = wr_val;
    assign busy        = (r_q.st == ST_WR) || (r_q.st == ST_RD) ||
                         (r_q.st == ST_CHK) || (r_q.st == ST_HOLD);
    assign done        = (r_q.st == ST_DONE) || (r_q.st == ST_FAIL);
    assign fail        = (r_q.st == ST_FAIL);
    assign fail_phase  = r_q.f_phase;
    assign fail_addr   = r_q.f_addr;
    assign fail_dev    = r_q.f_dev;
    assign fail_expect = r_q.f_exp;
    assign fail_actual = r_q.f_got;

    // R5
    rd_then_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> (!mem_re && !mem_we));

    // R8
    range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> ({1'b0, ADDR_W'(mem_addr - r_q.base)} < r_q.size));

    // R6
    fail_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (done && !busy));

    // R6
    no_access_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mem_we && !mem_re));

    // R10
    fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start) |=> (fail && $stable(fail_addr) && $stable(fail_phase)));

endmodule

// File: tb/ram_march_tester_test.sv
module ram_march_tester_test;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, start;
    logic [7:0]  cfg_base;
    logic [8:0]  cfg_size;
    logic [31:0] cfg_wait;
    logic [31:0] cfg_dev_base;
    logic [7:0]  mem_addr, mem_wdata, mem_rdata;
    logic        mem_we, mem_re, busy, done, fail;
    logic [1:0]  fail_phase, fail_dev;
    logic [7:0]  fail_addr, fail_expect, fail_actual;

    ram_march_tester uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_base(cfg_base),
        .cfg_size(cfg_size), .cfg_wait(cfg_wait), .cfg_dev_base(cfg_dev_base),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy),
        .done(done), .fail(fail), .fail_phase(fail_phase),
        .fail_addr(fail_addr), .fail_dev(fail_dev),
        .fail_expect(fail_expect), .fail_actual(fail_actual)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- RAM model with fault injection ----------------
    logic [7:0] ram [256];
    bit         stuck_on, alias_on, leak_on, leak_armed;
    logic [7:0] stuck_addr, stuck_mask, alias_src, alias_dst, leak_addr;
    int         idle_cnt;

    always @(posedge clk) begin
        if (mem_we) begin
            if (stuck_on && mem_addr == stuck_addr) ram[mem_addr] = mem_wdata & ~stuck_mask;
            else                                    ram[mem_addr] = mem_wdata;
            if (alias_on && mem_addr == alias_src) ram[alias_dst] = mem_wdata;
        end
        mem_rdata <= ram[mem_addr];
        if (start) begin
            idle_cnt   = 0;
            leak_armed = leak_on;
        end else if (mem_we || mem_re) idle_cnt = 0;
        else idle_cnt++;
        if (leak_armed && idle_cnt == 3) begin
            ram[leak_addr] = ram[leak_addr] ^ 8'h01;
            leak_armed = 1'b0;
        end
    end

    // ---------------- expected access trace ----------------
    bit         e_we   [1024];
    logic [7:0] e_addr [1024];
    logic [7:0] e_data [1024];
    string      e_req  [1024];
    int e_n, o_n, cyc, last_acc, ngap;
    int gaps [8];
    bit trace_on;

    task automatic push(input bit we, input logic [7:0] a, input logic [7:0] d, input string rq);
        e_we[e_n] = we; e_addr[e_n] = a; e_data[e_n] = d; e_req[e_n] = rq; e_n++;
    endtask

    task automatic build_expected(input logic [7:0] b, input int n);
        e_n = 0; o_n = 0; ngap = 0; last_acc = -1;
        for (int i = 0; i < n; i++) begin
            push(1, b + 8'(i), 8'h55, "R2"); push(0, b + 8'(i), 0, "R2");
            push(1, b + 8'(i), 8'hAA, "R2"); push(0, b + 8'(i), 0, "R2");
        end
        for (int i = 0; i < n; i++) push(1, b + 8'(i), 8'h00, "R3");
        for (int i = 0; i < n; i++) begin push(0, b + 8'(i), 0, "R3"); push(1, b + 8'(i), 8'hFF, "R3"); end
        for (int i = 0; i < n; i++) begin push(0, b + 8'(i), 0, "R3"); push(1, b + 8'(i), 8'h00, "R3"); end
        for (int i = n - 1; i >= 0; i--) begin push(0, b + 8'(i), 0, "R3"); push(1, b + 8'(i), 8'hFF, "R3"); end
        for (int i = n - 1; i >= 0; i--) begin push(0, b + 8'(i), 0, "R3"); push(1, b + 8'(i), 8'h00, "R3"); end
        for (int i = 0; i < n; i++) push(0, b + 8'(i), 0, "R3");
        for (int i = 0; i < n; i++) push(1, b + 8'(i), 8'h55, "R4");
        for (int i = 0; i < n; i++) push(0, b + 8'(i), 0, "R4");
        for (int i = 0; i < n; i++) push(1, b + 8'(i), 8'hAA, "R4");
        for (int i = 0; i < n; i++) push(0, b + 8'(i), 0, "R4");
    endtask

    always @(negedge clk) begin
        cyc++;
        if (trace_on && (mem_we || mem_re)) begin
            if (o_n >= e_n) begin
                chk(0, "R8", "extra access count", o_n + 1, e_n);
            end else begin
                chk(mem_we == e_we[o_n] && mem_re == !e_we[o_n] && mem_addr == e_addr[o_n]
                    && (!mem_we || mem_wdata == e_data[o_n]),
                    e_req[o_n], "access addr/data", {mem_we, mem_addr, mem_wdata},
                    {e_we[o_n], e_addr[o_n], e_data[o_n]});
            end
            if (last_acc >= 0 && cyc - last_acc > 2 && ngap < 8) begin
                gaps[ngap] = cyc - last_acc;
                ngap++;
            end
            last_acc = cyc;
            o_n++;
        end
    end

    // ---------------- run control ----------------
    task automatic fill_ram();
        for (int i = 0; i < 256; i++) ram[i] = 8'h3C;
    endtask

    task automatic clear_faults();
        stuck_on = 0; alias_on = 0; leak_on = 0;
    endtask

    task automatic run(input logic [7:0] b, input int n, input int w, input bit poke);
        cfg_base = b; cfg_size = 9'(n); cfg_wait = 32'(w);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int k = 0; k < 20000 && !done; k++) begin
            if (poke && k == 40) begin cfg_base = 8'h40; start = 1'b1; end
            @(negedge clk);
            if (poke && k == 40) begin cfg_base = b; start = 1'b0; end
        end
        chk(done, "R6", "run finished", done, 1);
    endtask

    task automatic expect_fail(input int ph, input logic [7:0] a, input int dv,
                               input logic [7:0] ex, input logic [7:0] got, input string rq);
        chk(fail == 1'b1, "R6", "fail flag", fail, 1);
        chk(fail_phase == 2'(ph), rq, "fail_phase", fail_phase, ph);
        chk(fail_addr == a, "R6", "fail_addr", fail_addr, a);
        chk(fail_dev == 2'(dv), "R7", "fail_dev", fail_dev, dv);
        chk(fail_expect == ex && fail_actual == got, "R6", "fail exp/act",
            {fail_expect, fail_actual}, {ex, got});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog run did not end actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; trace_on = 0; cyc = 0;
        cfg_base = 8'h10; cfg_size = 9'd16; cfg_wait = 32'd5;
        cfg_dev_base = {8'h1C, 8'h18, 8'h14, 8'h10};
        clear_faults(); fill_ram();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(!busy && !done && !fail && !mem_we && !mem_re, "R1", "idle after reset",
            {busy, done, fail, mem_we, mem_re}, 0);

        // good run with trace, mid-run start ignored (R10)
        build_expected(8'h10, 16); trace_on = 1;
        run(8'h10, 16, 5, 1);
        trace_on = 0;
        chk(!fail, "R10", "good run no fail after ignored start", fail, 0);
        chk(o_n == e_n, "R3", "access count", o_n, e_n);
        chk(ngap == 2 && gaps[0] == 7 && gaps[1] == 7, "R4", "retention gap",
            gaps[0], 7);
        for (int i = 0; i < 16; i++)
            chk(ram[8'h10 + i] == 8'hAA, "R4", "final contents", ram[8'h10 + i], 8'hAA);
        chk(ram[8'h0F] == 8'h3C && ram[8'h20] == 8'h3C, "R8", "outside window",
            {ram[8'h0F], ram[8'h20]}, 16'h3C3C);
        repeat (3) @(negedge clk);
        chk(done && !fail, "R10", "result held", {done, fail}, 2);

        // small window, long wait
        fill_ram();
        build_expected(8'h40, 3); trace_on = 1;
        run(8'h40, 3, 40, 0);
        trace_on = 0;
        chk(o_n == e_n && !fail, "R2", "small window count", o_n, e_n);
        chk(ngap == 2 && gaps[0] == 42 && gaps[1] == 42, "R4", "long retention gap",
            gaps[0], 42);

        // R9 empty window
        build_expected(8'h10, 0); trace_on = 1;
        cfg_size = 9'd0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(done && !fail && !busy, "R9", "empty window done", {done, fail, busy}, 4);
        repeat (3) @(negedge clk);
        chk(o_n == 0, "R9", "no access on empty", o_n, 0);
        trace_on = 0;

        // stuck bit 0 swept over every address: quick phase catches it
        for (int x = 16; x < 32; x++) begin
            fill_ram(); clear_faults();
            stuck_on = 1; stuck_addr = 8'(x); stuck_mask = 8'h01;
            run(8'h10, 16, 5, 0);
            expect_fail(1, 8'(x), (x - 16) / 4, 8'h55, 8'h54, "R2");
            if (x < 31) chk(ram[x + 1] == 8'h3C, "R6", "halt before next addr", ram[x + 1], 8'h3C);
        end
        // stuck bit 7: fails on the 0xAA half
        fill_ram(); clear_faults();
        stuck_on = 1; stuck_addr = 8'h19; stuck_mask = 8'h80;
        run(8'h10, 16, 5, 0);
        expect_fail(1, 8'h19, 2, 8'hAA, 8'h2A, "R2");

        // alias low->high: ascending march catches it
        fill_ram(); clear_faults();
        alias_on = 1; alias_src = 8'h12; alias_dst = 8'h17;
        run(8'h10, 16, 5, 0);
        expect_fail(2, 8'h17, 1, 8'h00, 8'hFF, "R3");
        // alias high->low: descending march catches it
        fill_ram(); clear_faults();
        alias_on = 1; alias_src = 8'h1A; alias_dst = 8'h13;
        run(8'h10, 16, 5, 0);
        expect_fail(2, 8'h13, 0, 8'h00, 8'hFF, "R3");

        // leaking cell during retention wait
        fill_ram(); clear_faults();
        leak_on = 1; leak_addr = 8'h1D;
        run(8'h10, 16, 5, 0);
        expect_fail(3, 8'h1D, 3, 8'h55, 8'h54, "R4");

        // device table whose first base lies above the window start
        cfg_dev_base = {8'h1C, 8'h18, 8'h14, 8'h12};
        for (int x = 16; x < 22; x++) begin
            fill_ram(); clear_faults();
            stuck_on = 1; stuck_addr = 8'(x); stuck_mask = 8'h01;
            run(8'h10, 16, 5, 0);
            expect_fail(1, 8'(x), (x < 20) ? 0 : 1, 8'h55, 8'h54, "R7");
        end
        clear_faults();

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule